// File: doc/BRIEF.md
# Interrupt Pending and Priority Arbiter

This block keeps the interrupt bookkeeping of one processor. Three 256-bit vectors hold the interrupts that are waiting (pending), the ones being serviced (in-service) and the ones that arrived level-triggered (trigger flags). Each vector number maps to word `vec[7:5]` and bit `vec[4:0]` of an eight-word, 32-bit-per-word store. From a software-written task priority and the highest vector in service, the block derives a processor priority. The highest pending vector is offered to the core only when its priority class is above that level.

The core takes an offered vector with a one-cycle acknowledge request and gets a grant back in the same cycle. At the following clock edge the vector moves from pending to in-service. An end-of-interrupt strobe retires the highest in-service vector. When that vector was level-triggered, a one-cycle broadcast carrying the vector number tells the external interrupt routers to re-sample the line. The task priority can be written as a full byte, or as a 4-bit "class only" view that maps onto bits 7:4.

Top module: `vpa_core`

## Requirements
- R1: After reset, nothing is pending or in service, the task priority and processor priority read 0, no vector is offered and the broadcast output is low.
- R2: An enabled accept marks its vector pending. The offered vector is always the highest-numbered pending one, across word boundaries.
- R3: The processor priority equals the task priority byte when task-priority bits 7:4 are at least bits 7:4 of the highest in-service vector. Otherwise it equals that vector with its low four bits cleared. An empty in-service set counts as vector 0.
- R4: A pending vector is offered (`irq_avail`=1) only when both enables are high and its class (vector with bits 3:0 cleared) is strictly greater than the processor priority.
- R5: With `ack_req` high while a vector is offered, `ack_grant` is high in that same cycle and `irq_vec` names the vector. After the clock edge the vector is in service and no longer pending.
- R6: An end-of-interrupt retires only the highest in-service vector and updates the priority. With nothing in service it changes nothing.
- R7: When the retired vector was level-triggered, `eoi_bcast` is high for exactly the one cycle after the end-of-interrupt edge, with `eoi_bcast_vec` equal to that vector. The vector's trigger flag is cleared at the same time. An edge-triggered retirement raises no broadcast.
- R8: A level-triggered accept of a vector that is already pending is discarded and leaves its trigger flag unchanged. An edge-triggered accept always marks the vector pending and clears its trigger flag.
- R9: Accepts arriving while `hw_en` or `sw_en` is low are dropped. They are not remembered once the unit is enabled again.
- R10: A 4-bit class write sets the task priority to the value shifted left by four. `cr8_rdata` returns task-priority bits 7:4. A byte write takes precedence when both writes arrive in the same cycle.
- R11: When an accept and an acknowledge name the same vector in one cycle, the acknowledge is applied first. The vector ends up both in service and pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| acc_valid | input | 1 | Accept strobe |
| acc_vec | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| tpr_wr | input | 1 | Task priority byte write |
| tpr_wdata | input | 8 | Task priority byte |
| cr8_wr | input | 1 | 4-bit class write |
| cr8_wdata | input | 4 | Class value |
| tpr_rdata | output | 8 | Task priority read |
| cr8_rdata | output | 4 | Task priority bits 7:4 |
| ppr | output | 8 | Processor priority |
| irq_avail | output | 1 | A vector is offered |
| irq_vec | output | 8 | Offered vector |
| ack_req | input | 1 | Acknowledge request |
| ack_grant | output | 1 | Acknowledge granted this cycle |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_bcast | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
All stored state changes at the rising edge that samples a strobe. Offer, priority and read outputs are combinational from that state, so they are due at the next falling edge. `ack_grant` depends only on the current state and `ack_req`, so it is due in the cycle of the request itself. The broadcast is registered: it is due at the falling edge one cycle after the end-of-interrupt was driven, and must be gone one cycle later. The bench drives every input at a falling edge. It checks combinational results 1 ns after driving and registered results at the falling edge after the sampling rising edge, so each check lands in the cycle it is due.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int unsigned NUM_VEC   = 256;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned VEC_W     = $clog2(NUM_VEC);
  localparam int unsigned SUB_W     = 4;
  localparam int unsigned CLASS_W   = VEC_W - SUB_W;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/vpa_top_find.sv
module vpa_top_find #(
  parameter int unsigned N     = vpa_pkg::NUM_VEC,
  parameter int unsigned WBITS = vpa_pkg::WORD_BITS,
  localparam int unsigned IW   = $clog2(N),
  localparam int unsigned NW   = N / WBITS,
  localparam int unsigned WW   = $clog2(NW),
  localparam int unsigned BW   = $clog2(WBITS)
) (
  input  logic [N-1:0]  bits,
  output logic          vld,
  output logic [IW-1:0] idx
);
  logic [NW-1:0]    word_nz;
  logic [WW-1:0]    top_w;
  logic [BW-1:0]    top_b;
  logic [WBITS-1:0] sel_word;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign word_nz[w] = |bits[w*WBITS +: WBITS];
  end

  always_comb begin
    top_w = '0;
    for (int w = 0; w < NW; w++) begin
      if (word_nz[w]) top_w = WW'(w);
    end
    sel_word = bits[top_w*WBITS +: WBITS];
    top_b = '0;
    for (int b = 0; b < WBITS; b++) begin
      if (sel_word[b]) top_b = BW'(b);
    end
  end

  assign vld = |word_nz;
  assign idx = {top_w, top_b};
endmodule

// File: rtl/vpa_prio.sv
module vpa_prio #(
  parameter int unsigned VW = vpa_pkg::VEC_W,
  parameter int unsigned SW = vpa_pkg::SUB_W
) (
  input  logic [VW-1:0] tpr,
  input  logic          isr_vld,
  input  logic [VW-1:0] isr_top,
  output logic [VW-1:0] ppr
);
  logic [VW-1:0] isr_eff;

  always_comb begin
    isr_eff = isr_vld ? isr_top : '0;
    if (tpr[VW-1:SW] >= isr_eff[VW-1:SW]) ppr = tpr;
    else                                  ppr = {isr_eff[VW-1:SW], {SW{1'b0}}};
  end
endmodule

// File: rtl/vpa_offer.sv
module vpa_offer #(
  parameter int unsigned VW = vpa_pkg::VEC_W,
  parameter int unsigned SW = vpa_pkg::SUB_W
) (
  input  logic          enabled,
  input  logic          irr_vld,
  input  logic [VW-1:0] irr_top,
  input  logic [VW-1:0] ppr,
  output logic          avail
);
  logic [VW-1:0] cls;

  assign cls   = {irr_top[VW-1:SW], {SW{1'b0}}};
  assign avail = enabled && irr_vld && (cls > ppr);
endmodule

// File: rtl/vpa_core.sv
module vpa_core #(
  parameter int unsigned NUM_VEC   = vpa_pkg::NUM_VEC,
  parameter int unsigned WORD_BITS = vpa_pkg::WORD_BITS,
  localparam int unsigned VW       = $clog2(NUM_VEC),
  localparam int unsigned SW       = vpa_pkg::SUB_W,
  localparam int unsigned CW       = VW - SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          sw_en,
  input  logic          acc_valid,
  input  logic [VW-1:0] acc_vec,
  input  logic          acc_level,
  input  logic          tpr_wr,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          cr8_wr,
  input  logic [CW-1:0] cr8_wdata,
  output logic [VW-1:0] tpr_rdata,
  output logic [CW-1:0] cr8_rdata,
  output logic [VW-1:0] ppr,
  output logic          irq_avail,
  output logic [VW-1:0] irq_vec,
  input  logic          ack_req,
  output logic          ack_grant,
  input  logic          eoi,
  output logic          eoi_bcast,
  output logic [VW-1:0] eoi_bcast_vec
);
  logic [NUM_VEC-1:0] irr_q, irr_n;
  logic [NUM_VEC-1:0] isr_q, isr_n;
  logic [NUM_VEC-1:0] tmr_q, tmr_n;
  logic [VW-1:0]      tpr_q, tpr_n;
  logic               bc_vld_q, bc_vld_n;
  logic [VW-1:0]      bc_vec_q, bc_vec_n;

  logic          enabled;
  logic          irr_vld, isr_vld;
  logic [VW-1:0] irr_top, isr_top;

  assign enabled = hw_en && sw_en;

  vpa_top_find #(.N(NUM_VEC), .WBITS(WORD_BITS)) i_irr_find (
    .bits(irr_q), .vld(irr_vld), .idx(irr_top)
  );

  vpa_top_find #(.N(NUM_VEC), .WBITS(WORD_BITS)) i_isr_find (
    .bits(isr_q), .vld(isr_vld), .idx(isr_top)
  );

  vpa_prio #(.VW(VW), .SW(SW)) i_prio (
    .tpr(tpr_q), .isr_vld(isr_vld), .isr_top(isr_top), .ppr(ppr)
  );

  vpa_offer #(.VW(VW), .SW(SW)) i_offer (
    .enabled(enabled), .irr_vld(irr_vld), .irr_top(irr_top),
    .ppr(ppr), .avail(irq_avail)
  );

  assign irq_vec       = irr_top;
  assign ack_grant     = ack_req && irq_avail;
  assign tpr_rdata     = tpr_q;
  assign cr8_rdata     = tpr_q[VW-1:SW];
  assign eoi_bcast     = bc_vld_q;
  assign eoi_bcast_vec = bc_vec_q;

  // Order inside one cycle: retire, then acknowledge, then accept.
  always_comb begin
    irr_n    = irr_q;
    isr_n    = isr_q;
    tmr_n    = tmr_q;
    tpr_n    = tpr_q;
    bc_vld_n = 1'b0;
    bc_vec_n = bc_vec_q;

    if (tpr_wr)      tpr_n = tpr_wdata;
    else if (cr8_wr) tpr_n = {cr8_wdata, {SW{1'b0}}};

    if (eoi && isr_vld) begin
      isr_n[isr_top] = 1'b0;
      if (tmr_q[isr_top]) begin
        tmr_n[isr_top] = 1'b0;
        bc_vld_n       = 1'b1;
        bc_vec_n       = isr_top;
      end
    end

    if (ack_grant) begin
      isr_n[irr_top] = 1'b1;
      irr_n[irr_top] = 1'b0;
    end

    if (acc_valid && enabled) begin
      if (!(irr_n[acc_vec] && acc_level)) begin
        irr_n[acc_vec] = 1'b1;
        tmr_n[acc_vec] = acc_level;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q    <= '0;
      isr_q    <= '0;
      tmr_q    <= '0;
      tpr_q    <= '0;
      bc_vld_q <= 1'b0;
      bc_vec_q <= '0;
    end else begin
      irr_q    <= irr_n;
      isr_q    <= isr_n;
      tmr_q    <= tmr_n;
      tpr_q    <= tpr_n;
      bc_vld_q <= bc_vld_n;
      bc_vec_q <= bc_vec_n;
    end
  end

  // R5
  ack_isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_grant |=> isr_q[$past(irr_top)] && !irr_q[$past(irr_top)] || $past(acc_valid));

  // R4
  offer_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_avail |-> !isr_q[irq_vec]);

  // R6
  eoi_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !isr_vld && !ack_grant) |=> !bc_vld_q && $stable(isr_q));

  // R7
  bcast_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_vld_q |-> $past(eoi) && $past(isr_vld) && !tmr_q[bc_vec_q] || $past(acc_valid));

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> $stable(irr_q));
endmodule

// File: tb/test_vpa_core.sv
module test_vpa_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_en = 1'b1, sw_en = 1'b1;
  logic       acc_valid = 1'b0, acc_level = 1'b0;
  logic [7:0] acc_vec = '0;
  logic       tpr_wr = 1'b0, cr8_wr = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic [3:0] cr8_wdata = '0;
  logic [7:0] tpr_rdata, ppr, irq_vec, eoi_bcast_vec;
  logic [3:0] cr8_rdata;
  logic       irq_avail, ack_req = 1'b0, ack_grant, eoi = 1'b0, eoi_bcast;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vpa_core i_vpa_core (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .cr8_wr(cr8_wr), .cr8_wdata(cr8_wdata),
    .tpr_rdata(tpr_rdata), .cr8_rdata(cr8_rdata), .ppr(ppr),
    .irq_avail(irq_avail), .irq_vec(irq_vec), .ack_req(ack_req), .ack_grant(ack_grant),
    .eoi(eoi), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hw_en = 1'b1; sw_en = 1'b1;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic accept(input logic [7:0] v, input logic lvl);
    acc_valid = 1'b1; acc_vec = v; acc_level = lvl;
    tick();
    acc_valid = 1'b0;
  endtask

  task automatic ack(input string req, input logic [7:0] exp_v);
    ack_req = 1'b1;
    #1;
    chk({req, " grant"}, int'(ack_grant), 1);
    chk({req, " granted vector"}, int'(irq_vec), int'(exp_v));
    tick();
    ack_req = 1'b0;
  endtask

  task automatic retire();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic write_tpr(input logic [7:0] v);
    tpr_wr = 1'b1; tpr_wdata = v;
    tick();
    tpr_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 avail", int'(irq_avail), 0);
    chk("R1 ppr", int'(ppr), 0);
    chk("R1 tpr", int'(tpr_rdata), 0);
    chk("R1 cr8", int'(cr8_rdata), 0);
    chk("R1 bcast", int'(eoi_bcast), 0);
  endtask

  task automatic t_highest_pending();
    do_reset();
    accept(8'h21, 1'b0);
    chk("R2 single", int'(irq_vec), 'h21);
    accept(8'hE3, 1'b0);
    accept(8'h87, 1'b0);
    chk("R2 highest", int'(irq_vec), 'hE3);
    do_reset();
    accept(8'h3F, 1'b0);
    accept(8'h40, 1'b0);
    chk("R2 word boundary", int'(irq_vec), 'h40);
  endtask

  task automatic t_offer_rule();
    do_reset();
    accept(8'h0F, 1'b0);
    chk("R4 class 0 not offered", int'(irq_avail), 0);
    write_tpr(8'h5F);
    accept(8'h5A, 1'b0);
    chk("R4 equal class blocked", int'(irq_avail), 0);
    accept(8'h60, 1'b0);
    chk("R4 higher class offered", int'(irq_avail), 1);
    chk("R4 offered vector", int'(irq_vec), 'h60);
  endtask

  task automatic t_ack_and_ppr();
    do_reset();
    write_tpr(8'h20);
    accept(8'h81, 1'b0);
    ack("R5", 8'h81);
    chk("R3 ppr from isr", int'(ppr), 'h80);
    chk("R5 no longer pending", int'(irq_avail), 0);
    write_tpr(8'h95);
    chk("R3 ppr from tpr", int'(ppr), 'h95);
  endtask

  task automatic t_nested_eoi();
    do_reset();
    accept(8'h41, 1'b0);
    ack("R5 first", 8'h41);
    accept(8'h91, 1'b0);
    ack("R5 nested", 8'h91);
    chk("R3 nested ppr", int'(ppr), 'h90);
    retire();
    chk("R6 highest retired", int'(ppr), 'h40);
    chk("R7 edge no bcast", int'(eoi_bcast), 0);
    retire();
    chk("R6 all retired", int'(ppr), 0);
  endtask

  task automatic t_eoi_empty();
    do_reset();
    write_tpr(8'h33);
    retire();
    chk("R6 empty eoi ppr", int'(ppr), 'h33);
    chk("R6 empty eoi bcast", int'(eoi_bcast), 0);
  endtask

  task automatic t_level_bcast();
    do_reset();
    accept(8'h62, 1'b1);
    ack("R7", 8'h62);
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
    chk("R7 bcast pulse", int'(eoi_bcast), 1);
    chk("R7 bcast vector", int'(eoi_bcast_vec), 'h62);
    tick();
    chk("R7 bcast one cycle", int'(eoi_bcast), 0);
    accept(8'h62, 1'b0);
    ack("R7 reuse", 8'h62);
    retire();
    chk("R7 trigger flag cleared", int'(eoi_bcast), 0);
  endtask

  task automatic t_level_duplicate();
    do_reset();
    accept(8'h70, 1'b0);
    accept(8'h70, 1'b1);
    ack("R8", 8'h70);
    retire();
    chk("R8 level dup discarded", int'(eoi_bcast), 0);
    accept(8'h71, 1'b1);
    accept(8'h71, 1'b0);
    ack("R8 edge over level", 8'h71);
    retire();
    chk("R8 edge clears trigger", int'(eoi_bcast), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    sw_en = 1'b0;
    accept(8'h90, 1'b0);
    sw_en = 1'b1;
    tick();
    chk("R9 sw disabled dropped", int'(irq_avail), 0);
    hw_en = 1'b0;
    accept(8'hA0, 1'b0);
    hw_en = 1'b1;
    tick();
    chk("R9 hw disabled dropped", int'(irq_avail), 0);
    accept(8'hB0, 1'b0);
    hw_en = 1'b0;
    #1;
    chk("R4 no offer while disabled", int'(irq_avail), 0);
    hw_en = 1'b1;
    #1;
    chk("R4 offer after enable", int'(irq_vec), 'hB0);
  endtask

  task automatic t_cr8();
    do_reset();
    cr8_wr = 1'b1; cr8_wdata = 4'h9;
    tick();
    cr8_wr = 1'b0;
    chk("R10 cr8 to tpr", int'(tpr_rdata), 'h90);
    chk("R10 cr8 read", int'(cr8_rdata), 'h9);
    write_tpr(8'hA7);
    chk("R10 cr8 of byte", int'(cr8_rdata), 'hA);
    chk("R3 ppr follows tpr", int'(ppr), 'hA7);
    tpr_wr = 1'b1; tpr_wdata = 8'h12; cr8_wr = 1'b1; cr8_wdata = 4'hC;
    tick();
    tpr_wr = 1'b0; cr8_wr = 1'b0;
    chk("R10 byte write wins", int'(tpr_rdata), 'h12);
  endtask

  task automatic t_same_cycle();
    do_reset();
    accept(8'h33, 1'b0);
    acc_valid = 1'b1; acc_vec = 8'h33; acc_level = 1'b0;
    ack("R11", 8'h33);
    acc_valid = 1'b0;
    chk("R11 in service", int'(ppr), 'h30);
    chk("R11 repending not offered", int'(irq_avail), 0);
    retire();
    chk("R11 pending again", int'(irq_avail), 1);
    chk("R11 pending vector", int'(irq_vec), 'h33);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_highest_pending();
    t_offer_rule();
    t_ack_and_ppr();
    t_nested_eoi();
    t_eoi_empty();
    t_level_bcast();
    t_level_duplicate();
    t_disabled();
    t_cr8();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule